// File: doc/BRIEF.md
# Hardware Trigger Conditioning Unit

This block turns one line out of a wide bus of hardware trigger sources into a clean start request for a conversion sequencer. A select field picks the line, a polarity bit decides whether a rising or a falling transition counts, and a bypass bit decides whether the level is taken straight from the bus or after a two-stage synchronizer. Each qualifying transition produces a single-cycle launch pulse. No pulse is produced while the unit is disabled.

The unit is enabled by a single level input. The history of the edge detector is held in the inactive state while the unit is disabled. Enabling the unit while the chosen line already sits at its active level therefore launches at once. Every bus line has its own synchronizer that runs all the time. A new select or polarity value that arrives in the same cycle as the enable is judged only on the newly chosen line, so the previous setting cannot cause a stale launch.

Top module: `trig_launch_cond`

## Requirements
- R1: `trig_sel` is an unsigned binary index: value n selects `trig_bus[n]`. Activity on every other bus line has no effect on `launch`.
- R2: With `rise_pol`=1 a 0-to-1 transition of the chosen line qualifies. With `rise_pol`=0 a 1-to-0 transition qualifies. A transition in the other direction never launches.
- R3: With `sync_skip`=1, `launch` is high in the cycle that follows the first rising clock edge that samples the new level.
- R4: With `sync_skip`=0, the level passes two flops first, so `launch` rises two cycles later than in R3.
- R5: Each qualifying transition gives exactly one `launch` cycle. Holding the active level does not launch again.
- R6: While `seq_en` is 0, `launch` stays 0. Transitions that happen and are undone while disabled cause no launch when the unit is enabled later.
- R7: If `seq_en` rises while the chosen line is already at its active level (and, on the synchronized path, has been stable for two cycles), `launch` follows after one clock edge. Enabling at the inactive level does not launch.
- R8: When `trig_sel` or `rise_pol` change in the same cycle that `seq_en` rises, only the new selection and polarity are judged. A line that was active under the old setting causes no launch.
- R9: A level that lasts one clock period and is seen by one rising edge is detected on both paths, giving exactly one launch.
- R10: During and right after the asynchronous active-low reset, `launch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_bus | input | NUM_TRIG | Hardware trigger source lines |
| trig_sel | input | SEL_W | Index of the chosen trigger line |
| rise_pol | input | 1 | 1: rising transition qualifies, 0: falling |
| sync_skip | input | 1 | 1: take the raw line, 0: take the synchronized line |
| seq_en | input | 1 | Unit enable |
| launch | output | 1 | One-cycle start request to the sequencer |

## Verification
The two functions that can meet in one cycle are the enable turning on and the selection or polarity changing. The bench provokes this by keeping the old line active and the new line inactive (or by flipping polarity over a steady line), then raising enable and rewriting the configuration in the same cycle. The result is judged by the absence of any launch over the next cycles. The opposite case, enabling while the chosen line is truly active, must launch after exactly one edge. Both latencies are computed from the number of synchronizer stages.

// File: rtl/trig_launch_pkg.sv
package trig_launch_pkg;

    // state of the edge detector: history of the normalized level and the output pulse
    typedef struct packed {
        logic hist;
        logic launch;
    } edge_state_t;

endpackage

// File: rtl/trig_sync_bank.sv
module trig_sync_bank #(
    parameter int N      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_bus,
    output logic [N-1:0] sync_bus
);

    generate
        if (STAGES == 0) begin : g_none
            assign sync_bus = raw_bus;
        end else begin : g_flops
            typedef struct packed {
                logic [STAGES-1:0][N-1:0] stg;
            } sync_state_t;

            sync_state_t state_d, state_q;

            always_comb begin
                state_d = state_q;
                state_d.stg[0] = raw_bus;
                for (int s = 1; s < STAGES; s++) begin
                    state_d.stg[s] = state_q.stg[s-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= '0;
                end else begin
                    state_q <= state_d;
                end
            end

            assign sync_bus = state_q.stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/trig_select.sv
module trig_select #(
    parameter int N     = 64,
    parameter int SEL_W = 6
) (
    input  logic [N-1:0]     raw_bus,
    input  logic [N-1:0]     sync_bus,
    input  logic [SEL_W-1:0] sel,
    input  logic             skip,
    input  logic             rise_pol,
    output logic             active
);

    logic lvl;
    logic in_range;

    always_comb begin
        in_range = (int'(sel) < N);
        lvl      = 1'b0;
        if (in_range) begin
            lvl = skip ? raw_bus[sel] : sync_bus[sel];
        end
        // normalize so that 1 always means the active level
        active = in_range & (rise_pol ? lvl : ~lvl);
    end

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import trig_launch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic active,
    output logic launch
);

    edge_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // history is forced inactive while disabled so enabling at the active level fires
        state_d.hist   = en & active;
        state_d.launch = en & active & ~state_q.hist;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign launch = state_q.launch;

endmodule

// File: rtl/trig_launch_cond.sv
module trig_launch_cond #(
    parameter int NUM_TRIG    = 64,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_bus,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic                rise_pol,
    input  logic                sync_skip,
    input  logic                seq_en,
    output logic                launch
);

    logic [NUM_TRIG-1:0] sync_bus;
    logic                sel_active;

    trig_sync_bank #(
        .N      (NUM_TRIG),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_bus  (trig_bus),
        .sync_bus (sync_bus)
    );

    trig_select #(
        .N     (NUM_TRIG),
        .SEL_W (SEL_W)
    ) u_sel (
        .raw_bus  (trig_bus),
        .sync_bus (sync_bus),
        .sel      (trig_sel),
        .skip     (sync_skip),
        .rise_pol (rise_pol),
        .active   (sel_active)
    );

    trig_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (seq_en),
        .active (sel_active),
        .launch (launch)
    );

endmodule

// File: rtl/trig_launch_checker.sv
module trig_launch_checker #(
    parameter int NUM_TRIG = 64,
    parameter int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_TRIG-1:0] trig_bus,
    input logic [SEL_W-1:0]    trig_sel,
    input logic                rise_pol,
    input logic                sync_skip,
    input logic                seq_en,
    input logic                launch
);

    logic sel_lvl;
    assign sel_lvl = (int'(trig_sel) < NUM_TRIG) ? trig_bus[trig_sel] : 1'b0;

    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch); // R5

    AST_LAUNCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(seq_en)); // R6

    AST_BYPASS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en && $past(seq_en) && sync_skip && $past(sync_skip) && rise_pol &&
         $past(rise_pol) && $stable(trig_sel) && !$past(sel_lvl) && sel_lvl)
        |=> launch); // R3

    AST_ENABLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seq_en) && sync_skip && (sel_lvl == rise_pol)) |=> launch); // R7

endmodule

bind trig_launch_cond trig_launch_checker #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_bus  (trig_bus),
    .trig_sel  (trig_sel),
    .rise_pol  (rise_pol),
    .sync_skip (sync_skip),
    .seq_en    (seq_en),
    .launch    (launch)
);

// File: tb/sim_trig_launch_cond.sv
module sim_trig_launch_cond;

    localparam int N      = 64;
    localparam int STAGES = 2;
    localparam int SW     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  bus = '0;
    logic [SW-1:0] sel = '0;
    logic          pol = 1'b1;
    logic          skip = 1'b1;
    logic          en = 1'b0;
    logic          launch;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trig_launch_cond #(.NUM_TRIG(N), .SYNC_STAGES(STAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_bus(bus), .trig_sel(sel),
        .rise_pol(pol), .sync_skip(skip), .seq_en(en), .launch(launch)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // steps n falling edges; reports index of the first launch and the total number
    task automatic watch(input int n, output int first, output int cnt);
        first = -1;
        cnt = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (launch) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
    endtask

    function automatic logic [N-1:0] idle_bus(input logic p);
        return p ? '0 : '1;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int f;
        int c;
        int exp_lat;

        // R10 reset
        repeat (3) @(negedge clk);
        check(launch == 1'b0, "R10", launch, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(launch == 1'b0, "R10", launch, 0);
        repeat (3) @(negedge clk);

        // sweep all lines, both polarities, both paths
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < N; s++) begin
                    en = 1'b0; skip = b[0]; pol = p[0]; sel = SW'(s);
                    bus = idle_bus(p[0]);
                    watch(4, f, c);
                    en = 1'b1;
                    watch(4, f, c);
                    check(c == 0, "R7 enable at idle level", c, 0);
                    bus = ~idle_bus(p[0]);
                    bus[s] = idle_bus(p[0])[s];
                    watch(5, f, c);
                    check(c == 0, "R1 other lines", c, 0);
                    bus = idle_bus(p[0]);
                    watch(3, f, c);
                    bus[s] = p[0];
                    exp_lat = b ? 1 : 1 + STAGES;
                    watch(6, f, c);
                    check(f == exp_lat, b ? "R3 latency" : "R4 latency", f, exp_lat);
                    check(c == 1, "R5 single pulse", c, 1);
                    bus[s] = ~p[0];
                    watch(5, f, c);
                    check(c == 0, "R2 opposite edge", c, 0);
                end
            end
        end

        // R6 activity while disabled
        for (int b = 0; b < 2; b++) begin
            en = 1'b0; skip = b[0]; pol = 1'b1; sel = 6'd5; bus = '0;
            watch(3, f, c);
            bus[5] = 1'b1;
            watch(3, f, c);
            check(c == 0, "R6 disabled", c, 0);
            bus[5] = 1'b0;
            watch(4, f, c);
            en = 1'b1;
            watch(5, f, c);
            check(c == 0, "R6 no late launch", c, 0);
        end

        // R7 enable while active
        en = 1'b0; skip = 1'b0; pol = 1'b1; sel = 6'd9; bus = '0; bus[9] = 1'b1;
        watch(4, f, c);
        en = 1'b1;
        watch(5, f, c);
        check(f == 1 && c == 1, "R7 sync path", f * 10 + c, 11);
        en = 1'b0; skip = 1'b1; pol = 1'b0; sel = 6'd20; bus = '0;
        watch(4, f, c);
        en = 1'b1;
        watch(5, f, c);
        check(f == 1 && c == 1, "R7 bypass path", f * 10 + c, 11);

        // R8 selection change together with enable
        for (int b = 0; b < 2; b++) begin
            en = 1'b0; skip = b[0]; pol = 1'b1; sel = 6'd3; bus = '0; bus[3] = 1'b1;
            watch(4, f, c);
            sel = 6'd7; en = 1'b1;
            watch(5, f, c);
            check(c == 0, "R8 select change", c, 0);
            en = 1'b0; pol = 1'b0; sel = 6'd3; bus = '0;
            watch(4, f, c);
            pol = 1'b1; en = 1'b1;
            watch(5, f, c);
            check(c == 0, "R8 polarity change", c, 0);
        end

        // R9 one-period pulse
        for (int b = 0; b < 2; b++) begin
            int c2;
            en = 1'b0; skip = b[0]; pol = 1'b1; sel = 6'd12; bus = '0;
            watch(4, f, c);
            en = 1'b1;
            watch(2, f, c);
            bus[12] = 1'b1;
            watch(1, f, c);
            bus[12] = 1'b0;
            watch(6, f, c2);
            check(c + c2 == 1, "R9 short pulse", c + c2, 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule